// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits on the host side of a 16-bit asynchronous EDO DRAM. It takes word or byte read and write requests over a valid/ready interface. Each request is turned into strobe sequences on a shared 12-bit address bus: a row phase latched by the row strobe, then a column phase latched by one or both byte-lane column strobes. All writes are early writes. Reads run with write enable high and output enable low. Each read returns its word with a single-cycle response pulse.

After an access the row stays open. A later request to the same row runs as a page-mode column cycle and skips the row phase. A request to another row first closes the open row, waits out the precharge and then opens the new row. An age counter closes the row before the page-mode row-active limit runs out. A refresh block can ask for the bus with a request/grant handshake. All timing limits are given in nanoseconds and turned into whole clock cycles, rounded up.

Top module: `edo_page_ctrl`

## Requirements
- R1: After reset the row strobe, both column strobes, write enable and output enable are high (inactive), the data bus driver is off, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: The 22-bit request address is split as row = addr[21:10] and column = addr[9:0]. The row is on `dram_addr_o` when the row strobe falls. The column, zero-extended to 12 bits, is on `dram_addr_o` when a column strobe falls.
- R3: Byte enable bit 0 selects the lower column strobe (data bits 7:0) and bit 1 selects the upper one (bits 15:8). A word access asserts both strobes. A column strobe is low only while the row strobe is low.
- R4: On a write, write enable is already low one cycle before the column strobe falls. `dram_dq_o` carries the write data with `dram_dq_oe_o` set at that fall, and output enable stays high while the bus is driven.
- R5: On a read, write enable stays high and output enable is low. The word is sampled from `dram_dq_i` in the last cycle of column precharge, just before any next column-strobe fall. It is returned on `rsp_rdata_o` with `rsp_valid_o` high for exactly one cycle. Lanes that are not enabled carry whatever the bus holds.
- R6: Once it falls, the row strobe stays low for at least ceil(T_RAS_NS/CLK_NS) cycles. Once it rises, it stays high for at least ceil(T_RP_NS/CLK_NS) cycles.
- R7: The first column strobe of an opened row falls exactly ceil(T_RCD_NS/CLK_NS)+1 cycles after the row strobe falls. A column strobe stays low for at least ceil(T_CAS_NS/CLK_NS) cycles and stays high for at least ceil(T_CP_NS/CLK_NS) cycles between pulses.
- R8: A request to the open row (page hit) produces a column cycle only, with no row strobe transition.
- R9: A request to a different row raises the row strobe. The strobe then stays high for exactly ceil(T_RP_NS/CLK_NS) cycles before it falls with the new row.
- R10: The row strobe never stays low for more than ceil(T_RASP_NS/CLK_NS) cycles, even under a steady stream of page hits.
- R11: While `ref_req_i` is high, no request is accepted. The open row is closed, and `ref_gnt_o` is asserted only once the row strobe has been high for the precharge time with both column strobes high. After release, a full precharge runs before the next row strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_addr_i | input | 22 | Word address, row in bits 21:10, column in 9:0 |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle |
| rsp_rdata_o | output | 16 | Read data |
| ref_req_i | input | 1 | Refresh block asks for the DRAM |
| ref_gnt_o | output | 1 | DRAM handed to the refresh block |
| dram_addr_o | output | 12 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_lcas_no | output | 1 | Lower-lane column strobe, active low |
| dram_ucas_no | output | 1 | Upper-lane column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_dq_i | input | 16 | Data from the DRAM |
| dram_dq_o | output | 16 | Data to the DRAM |
| dram_dq_oe_o | output | 1 | Drive enable for `dram_dq_o` |

## Verification
Several input patterns are applied, and each separates a different fault:
- A word write followed by a word read to the same row tells a page-hit column cycle apart from a needless row reopen. It also shows whether the write data and lane strobes reach the bus.
- Lower-only and upper-only byte reads and writes show lane swaps and lanes left driven.
- A read to a new row exercises the close/precharge/reopen path. It shows the exact row-to-column delay and precharge length that follow from the cycle rounding.
- A long run of back-to-back page hits must still see the row closed before the page-mode limit.
- A refresh request taken with a row open checks that the grant waits for the precharge and that requests are held off during it.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CLOSE, S_PRE, S_ACT, S_CSET, S_CLOW, S_CHIGH, S_REF
  } edo_state_e;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/edo_phase_timer.sv
module edo_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/edo_row_age.sv
module edo_row_age #(
  parameter int RAS_CYC  = 5,
  parameter int CLOSE_AT = 100,
  parameter int MAX_CYC  = 110
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic row_open_i,
  output logic tras_met_o,
  output logic expire_o
);
  localparam int AW = $clog2(MAX_CYC + 1);

  logic [AW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   age_q <= '0;
    else if (!row_open_i)          age_q <= '0;
    else if (age_q != AW'(MAX_CYC)) age_q <= age_q + 1'b1;
  end

  assign tras_met_o = (age_q >= AW'(RAS_CYC - 1));
  assign expire_o   = (age_q >= AW'(CLOSE_AT));

  // R6
  ras_min_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(row_open_i) |-> ($past(age_q) >= AW'(RAS_CYC - 1)));

  // R10
  ras_max_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_open_i |-> (age_q < AW'(MAX_CYC)));

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int T_RAS_NS  = 50,
  parameter int T_RP_NS   = 30,
  parameter int T_RCD_NS  = 15,
  parameter int T_CAS_NS  = 13,
  parameter int T_CP_NS   = 9,
  parameter int T_AA_NS   = 25,
  parameter int T_RAC_NS  = 50,
  parameter int T_RASP_NS = 100000,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [ROW_W+COL_W-1:0]   req_addr_i,
  input  logic                     req_we_i,
  input  logic [1:0]               req_be_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  output logic                     rsp_valid_o,
  output logic [DATA_W-1:0]        rsp_rdata_o,
  input  logic                     ref_req_i,
  output logic                     ref_gnt_o,
  output logic [ROW_W-1:0]         dram_addr_o,
  output logic                     dram_ras_no,
  output logic                     dram_lcas_no,
  output logic                     dram_ucas_no,
  output logic                     dram_we_no,
  output logic                     dram_oe_no,
  input  logic [DATA_W-1:0]        dram_dq_i,
  output logic [DATA_W-1:0]        dram_dq_o,
  output logic                     dram_dq_oe_o
);
  localparam int ADDR_W   = ROW_W + COL_W;
  localparam int RAS_CYC  = ns2cyc(T_RAS_NS, CLK_NS);
  localparam int RP_CYC   = ns2cyc(T_RP_NS, CLK_NS);
  localparam int RCD_CYC  = ns2cyc(T_RCD_NS, CLK_NS);
  localparam int CP_CYC   = ns2cyc(T_CP_NS, CLK_NS);
  localparam int AA_CYC   = ns2cyc(T_AA_NS, CLK_NS);
  localparam int RAC_CYC  = ns2cyc(T_RAC_NS, CLK_NS);
  localparam int RASP_CYC = ns2cyc(T_RASP_NS, CLK_NS);
  // column low time also covers column-address and row access from the strobes
  localparam int CL_CYC   = max3(ns2cyc(T_CAS_NS, CLK_NS),
                                 max3(AA_CYC - 1, RAC_CYC - RCD_CYC - 1, 1), 1);
  localparam int GUARD    = CL_CYC + CP_CYC + 4;
  localparam int CLOSE_AT = (RASP_CYC > 2 * GUARD) ? RASP_CYC - GUARD : RASP_CYC / 2;
  localparam int TW       = $clog2(max3(RP_CYC, RCD_CYC, max3(CL_CYC, CP_CYC, 1)) + 1) + 1;

  edo_state_e state_q, state_d;
  logic              tmr_load, tmr_done, tras_met, expire, accept, hit;
  logic [TW-1:0]     tmr_val;
  logic              row_open_q, pend_q, we_q;
  logic [1:0]        be_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ROW_W-1:0]  open_row_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              cas_phase, cas_idle;

  edo_phase_timer #(.W(TW)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .done_o(tmr_done)
  );

  edo_row_age #(.RAS_CYC(RAS_CYC), .CLOSE_AT(CLOSE_AT), .MAX_CYC(RASP_CYC)) u_age (
    .clk_i, .rst_ni, .row_open_i(row_open_q), .tras_met_o(tras_met), .expire_o(expire)
  );

  assign hit         = row_open_q && (req_addr_i[ADDR_W-1:COL_W] == open_row_q);
  assign req_ready_o = (state_q == S_IDLE) && !ref_req_i && !(row_open_q && expire);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_IDLE: begin
        if (ref_req_i)                 state_d = row_open_q ? S_CLOSE : S_REF;
        else if (row_open_q && expire) state_d = S_CLOSE;
        else if (accept) begin
          if (hit)             state_d = S_CSET;
          else if (row_open_q) state_d = S_CLOSE;
          else begin
            state_d = S_ACT; tmr_load = 1'b1; tmr_val = TW'(RCD_CYC - 1);
          end
        end
      end
      S_CLOSE: if (tras_met) begin
        state_d = S_PRE; tmr_load = 1'b1; tmr_val = TW'(RP_CYC - 1);
      end
      S_PRE: if (tmr_done) begin
        if (pend_q) begin
          state_d = S_ACT; tmr_load = 1'b1; tmr_val = TW'(RCD_CYC - 1);
        end else if (ref_req_i) state_d = S_REF;
        else                    state_d = S_IDLE;
      end
      S_ACT: if (tmr_done) state_d = S_CSET;
      S_CSET: begin
        state_d = S_CLOW; tmr_load = 1'b1; tmr_val = TW'(CL_CYC - 1);
      end
      S_CLOW: if (tmr_done) begin
        state_d = S_CHIGH; tmr_load = 1'b1; tmr_val = TW'(CP_CYC - 1);
      end
      S_CHIGH: if (tmr_done) state_d = S_IDLE;
      S_REF: if (!ref_req_i) begin
        state_d = S_PRE; tmr_load = 1'b1; tmr_val = TW'(RP_CYC - 1);
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      row_open_q  <= 1'b0;
      open_row_q  <= '0;
      pend_q      <= 1'b0;
      we_q        <= 1'b0;
      be_q        <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= 1'b0;
      if (accept) begin
        pend_q  <= 1'b1;
        we_q    <= req_we_i;
        be_q    <= req_be_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (state_d == S_ACT && state_q != S_ACT) begin
        row_open_q <= 1'b1;
        open_row_q <= accept ? req_addr_i[ADDR_W-1:COL_W] : addr_q[ADDR_W-1:COL_W];
      end
      if (state_q == S_CLOSE && state_d == S_PRE) row_open_q <= 1'b0;
      if (state_q == S_CHIGH && tmr_done) begin
        pend_q <= 1'b0;
        if (!we_q) begin
          rsp_valid_q <= 1'b1;
          rdata_q     <= dram_dq_i;
        end
      end
    end
  end

  assign cas_phase    = (state_q == S_CLOW);
  assign dram_ras_no  = !row_open_q;
  assign dram_lcas_no = !(cas_phase && be_q[0]);
  assign dram_ucas_no = !(cas_phase && be_q[1]);
  assign dram_we_no   = !(we_q && (state_q == S_CSET || state_q == S_CLOW));
  assign dram_oe_no   = !(!we_q && (state_q == S_CSET || state_q == S_CLOW || state_q == S_CHIGH));
  assign dram_dq_oe_o = we_q && (state_q == S_CSET || state_q == S_CLOW);
  assign dram_dq_o    = wdata_q;
  assign dram_addr_o  = (state_q == S_ACT) ? addr_q[ADDR_W-1:COL_W] :
                        (state_q == S_CSET || cas_phase || state_q == S_CHIGH) ?
                        ROW_W'(addr_q[COL_W-1:0]) : '0;
  assign ref_gnt_o    = (state_q == S_REF);
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_rdata_o  = rdata_q;
  assign cas_idle     = dram_lcas_no && dram_ucas_no;

  // R3
  cas_in_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_idle |-> !dram_ras_no);

  // R4
  early_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_idle) && dram_dq_oe_o) |-> (!$past(dram_we_no) && dram_oe_no));

  // R4
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_dq_oe_o |-> dram_oe_no);

  // R5
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R11
  gnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_gnt_o |-> (dram_ras_no && cas_idle && !req_ready_o && !dram_dq_oe_o));

  // R8
  hit_keeps_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit) |=> !dram_ras_no);

endmodule

// File: tb/edo_page_ctrl_test.sv
module edo_page_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int RAS_C  = (50 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RP_C   = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RCD_C  = (15 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int CAS_C  = (13 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int CP_C   = (9 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RASP_C = (3000 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0, dq_model = '0;
  logic req_ready, rsp_valid, ref_gnt, ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;
  logic [15:0] rsp_rdata, dq_out;
  logic [11:0] dram_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  edo_page_ctrl #(.CLK_NS(CLK_PERIOD), .T_RASP_NS(3000)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_we_i(req_we), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .ref_req_i(ref_req), .ref_gnt_o(ref_gnt),
    .dram_addr_o(dram_addr), .dram_ras_no(ras_n), .dram_lcas_no(lcas_n),
    .dram_ucas_no(ucas_n), .dram_we_no(we_n), .dram_oe_no(oe_n),
    .dram_dq_i(dq_model), .dram_dq_o(dq_out), .dram_dq_oe_o(dq_oe)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input logic [11:0] r, input logic [9:0] c);
    return {r[7:0] ^ 8'hA5, c[7:0]} ^ {6'd0, c};
  endfunction

  // bus monitor and DRAM data model, sampled at falling clock edge
  logic prev_ras = 1, prev_cas = 1, prev_we = 1, seen_cas = 0;
  int hi_cnt = 1000, lo_cnt = 0, since_ras = 0, cas_lo = 0, cas_hi = 1000;
  int ras_falls = 0, cas_events = 0, rcd_meas = 0, last_hi = 0;
  logic [11:0] m_row = '0;
  logic [9:0]  m_col = '0;
  logic [1:0]  m_lanes = '0;
  logic        m_we = 1, m_we_prev = 1, m_oe = 1, m_dqoe = 0;
  logic [15:0] m_wdata = '0;

  always @(negedge clk) if (rst_n) begin
    logic cas_now;
    cas_now = lcas_n & ucas_n;
    if (prev_ras && !ras_n) begin
      chk(hi_cnt >= RP_C, "R6 precharge", hi_cnt, RP_C);
      last_hi = hi_cnt;
      m_row = dram_addr; ras_falls++; since_ras = 0; lo_cnt = 1; seen_cas = 0;
    end else if (!ras_n) begin
      lo_cnt++; since_ras++;
    end else if (!prev_ras && ras_n) begin
      chk(lo_cnt >= RAS_C, "R6 row active min", lo_cnt, RAS_C);
      chk(lo_cnt <= RASP_C, "R10 page limit", lo_cnt, RASP_C);
      hi_cnt = 1;
    end else hi_cnt++;
    if (prev_cas && !cas_now) begin
      chk(!ras_n, "R3 column inside row", ras_n, 0);
      chk(cas_hi >= CP_C, "R7 column precharge", cas_hi, CP_C);
      m_col = dram_addr[9:0]; m_lanes = {!ucas_n, !lcas_n};
      m_we = we_n; m_we_prev = prev_we; m_oe = oe_n; m_dqoe = dq_oe; m_wdata = dq_out;
      cas_events++; cas_lo = 1;
      if (!seen_cas) begin rcd_meas = since_ras; seen_cas = 1; end
      if (we_n)
        dq_model = {ucas_n ? 8'h00 : pat(m_row, m_col)[15:8],
                    lcas_n ? 8'h00 : pat(m_row, m_col)[7:0]};
    end else if (!cas_now) cas_lo++;
    else if (!prev_cas && cas_now) begin
      chk(cas_lo >= CAS_C, "R7 column pulse", cas_lo, CAS_C);
      cas_hi = 1;
    end else cas_hi++;
    prev_ras = ras_n; prev_cas = cas_now; prev_we = we_n;
  end

  task automatic issue(input logic [21:0] a, input logic w, input logic [1:0] be,
                       input logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_we = w; req_be = be; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_read(input logic [21:0] a, input logic [1:0] be, input string tag);
    logic [15:0] e;
    int n;
    issue(a, 1'b0, be, 16'h0);
    n = 0;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    e = {be[1] ? pat(a[21:10], a[9:0])[15:8] : 8'h00,
         be[0] ? pat(a[21:10], a[9:0])[7:0]  : 8'h00};
    chk(rsp_valid, {tag, " R5 response"}, rsp_valid, 1);
    chk(rsp_rdata == e, {tag, " R5 data"}, rsp_rdata, e);
    chk(m_we && !m_oe && !m_dqoe, {tag, " R5 read strobes"}, {m_we, m_oe, m_dqoe}, 3'b100);
    chk(m_lanes == be, {tag, " R3 lanes"}, m_lanes, be);
    chk(m_row == a[21:10] && m_col == a[9:0], {tag, " R2 address"}, {m_row, m_col}, a);
    @(negedge clk);
    chk(!rsp_valid, {tag, " R5 single pulse"}, rsp_valid, 0);
  endtask

  task automatic do_write(input logic [21:0] a, input logic [1:0] be, input logic [15:0] d,
                          input string tag);
    int c0, n;
    c0 = cas_events;
    issue(a, 1'b1, be, d);
    n = 0;
    while (cas_events == c0 && n < 100) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk(!m_we && !m_we_prev && m_oe && m_dqoe, {tag, " R4 early write"},
        {m_we, m_we_prev, m_oe, m_dqoe}, 4'b0011);
    chk(m_wdata == d, {tag, " R4 data"}, m_wdata, d);
    chk(m_lanes == be, {tag, " R3 lanes"}, m_lanes, be);
    chk(m_row == a[21:10] && m_col == a[9:0], {tag, " R2 address"}, {m_row, m_col}, a);
  endtask

  task automatic t_reset;
    chk(ras_n && lcas_n && ucas_n && we_n && oe_n, "R1 strobes idle",
        {ras_n, lcas_n, ucas_n, we_n, oe_n}, 5'h1f);
    chk(!dq_oe && req_ready && !rsp_valid && !ref_gnt, "R1 handshake",
        {dq_oe, req_ready, rsp_valid, ref_gnt}, 4'b0100);
  endtask

  task automatic t_word_and_hit;
    int rf;
    do_write({12'h123, 10'h045}, 2'b11, 16'hBEEF, "word write");
    chk(rcd_meas == RCD_C + 1, "R7 R12 row to column delay", rcd_meas, RCD_C + 1);
    rf = ras_falls;
    do_read({12'h123, 10'h3FF}, 2'b11, "word hit read");
    chk(ras_falls == rf && !ras_n, "R8 page hit keeps row", ras_falls, rf);
  endtask

  task automatic t_bytes;
    do_read({12'h123, 10'h010}, 2'b01, "lower read");
    do_read({12'h123, 10'h011}, 2'b10, "upper read");
    do_write({12'h123, 10'h012}, 2'b10, 16'h5A3C, "upper write");
    do_write({12'h123, 10'h013}, 2'b01, 16'hC3A5, "lower write");
  endtask

  task automatic t_miss;
    int rf;
    rf = ras_falls;
    do_read({12'hABC, 10'h200}, 2'b11, "miss read");
    chk(ras_falls == rf + 1, "R9 one reopen", ras_falls, rf + 1);
    chk(last_hi == RP_C, "R9 R12 exact precharge", last_hi, RP_C);
    chk(rcd_meas == RCD_C + 1, "R7 miss row to column", rcd_meas, RCD_C + 1);
  endtask

  task automatic t_page_limit;
    int rf;
    rf = ras_falls;
    for (int i = 0; i < 120; i++) do_read({12'hABC, 10'(i)}, 2'b11, "R10 stream");
    chk(ras_falls > rf, "R10 forced close", ras_falls, rf + 1);
  endtask

  task automatic t_refresh;
    int n, rf;
    do_read({12'h0F0, 10'h001}, 2'b01, "pre-refresh");
    @(negedge clk);
    ref_req = 1;
    n = 0;
    while (!ref_gnt && n < 100) begin @(negedge clk); n++; end
    chk(ref_gnt, "R11 grant", ref_gnt, 1);
    chk(ras_n && lcas_n && ucas_n && hi_cnt >= RP_C, "R11 closed at grant", hi_cnt, RP_C);
    rf = ras_falls;
    req_valid = 1; req_addr = {12'h0F0, 10'h002}; req_we = 0; req_be = 2'b11;
    repeat (6) @(negedge clk);
    chk(!req_ready && ras_falls == rf && ras_n, "R11 requests held", req_ready, 0);
    req_valid = 0;
    ref_req = 0;
    do_read({12'h0F0, 10'h002}, 2'b11, "post-refresh");
    chk(last_hi >= RP_C + 6, "R11 precharge after release", last_hi, RP_C + 6);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_word_and_hit;
    t_bytes;
    t_miss;
    t_page_limit;
    t_refresh;
    repeat (5) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule